// File: doc/BRIEF.md
# Serial quad DAC command receiver

This block is the digital front end of a four-channel 8-bit converter. It takes commands over a three-wire serial link: a serial clock, a data line and a load strobe. A separate update strobe sets when new codes reach the converters. All four serial-side inputs are asynchronous to the system clock. Each one is synchronised, and edges are found by comparing each sample with the one before it.

Bits are shifted in on falling serial-clock edges. A falling load edge takes the last eleven bits as one command: a channel select, a gain flag and an 8-bit code. The command is written into that channel's input register. The level of the update strobe at that moment picks one of two paths. If the strobe is low, the output register is written in the same step. If it is high, the write waits until a later falling edge of the strobe copies all four input registers to the outputs together. A load edge that arrives after fewer than eleven bits is rejected and raises an error flag.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset all four output codes are 0, all gain flags are 0 (x1) and err_o is 0.
- R2: Data is sampled on each falling edge of sclk_i, MSB first. In the eleven-bit command, bits 10:9 are the channel select, bit 8 is the gain flag and bits 7:0 are the code.
- R3: Select values 0, 1, 2 and 3 address channels A, B, C and D. These map to code_o[7:0], [15:8], [23:16] and [31:24], and to gain_o bits 0 to 3.
- R4: A gain bit of 1 sets the channel's gain_o bit (x2). A gain bit of 0 clears it (x1).
- R5: If more than eleven bits arrive before load_i falls, only the last eleven are used.
- R6: If fewer than eleven bits arrive before load_i falls, the command changes no register and err_o goes to 1. The next accepted command clears err_o.
- R7: If ldac_i is low when load_i falls, the addressed channel's outputs update at once.
- R8: If ldac_i is high when load_i falls, the outputs keep their values and only the input register is written.
- R9: A falling edge on ldac_i copies all four input registers to the outputs in the same cycle.
- R10: The bit count clears on every falling edge of load_i, whether the command was accepted or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| load_i | input | 1 | Command latch strobe; acts on its falling edge |
| ldac_i | input | 1 | Update strobe: its level selects the immediate or held path, and its falling edge transfers all channels |
| code_o | output | 32 | Output codes, channel A in the low byte |
| gain_o | output | 4 | Gain flags per channel, 1 means x2 |
| err_o | output | 1 | Set when the last completed command was too short |

## Verification
A wrong bit count or shift state shows up in the first command after it. The value lands on the wrong channel or with a shifted code, or err_o disagrees with the number of bits sent. Any of these is visible about a dozen system cycles after load_i falls. A fault in the held path shows on the outputs in one of two ways. Either the outputs change before ldac_i falls, or some channels fail to update within the same window after it falls. The bench sweeps every channel and gain with spread codes through both paths, so each such fault leaves a mismatch at the ports within one command.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  localparam int SEL_W  = 2;
  localparam int CODE_W = 8;
  localparam int N_CH   = 1 << SEL_W;
  localparam int CMD_W  = SEL_W + 1 + CODE_W;
  localparam int CNT_W  = $clog2(CMD_W + 1);

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              gain;
    logic [CODE_W-1:0] code;
  } cmd_t;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_rx_fall.sv
module dac_rx_fall #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/dac_rx_shift.sv
module dac_rx_shift
  import dac_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic             bit_i,
  input  logic             latch_i,
  output logic             wr_o,
  output logic             short_o,
  output cmd_t             cmd_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CMD_W-1:0] sh_q, sh_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    sh_nxt  = sh_q;
    cnt_nxt = cnt_q;
    if (bit_stb_i) begin
      sh_nxt = {sh_q[CMD_W-2:0], bit_i};
      if (cnt_q != CNT_W'(CMD_W)) cnt_nxt = cnt_q + 1'b1;  // saturate
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_nxt;
      cnt_q <= latch_i ? '0 : cnt_nxt;
    end
  end

  assign wr_o    = latch_i && (cnt_nxt == CNT_W'(CMD_W));
  assign short_o = latch_i && (cnt_nxt != CNT_W'(CMD_W));
  assign cmd_o   = cmd_t'(sh_nxt);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dac_rx_bank.sv
module dac_rx_bank
  import dac_rx_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  cmd_t                         cmd_i,
  input  logic                         hold_i,
  input  logic                         xfer_i,
  output logic [N_CH-1:0][CODE_W-1:0]  code_o,
  output logic [N_CH-1:0]              gain_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CODE_W-1:0] in_code_q, out_code_q;
    logic              in_gain_q, out_gain_q;
    logic              hit;

    assign hit = wr_i && (cmd_i.sel == SEL_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_code_q  <= '0;
        in_gain_q  <= 1'b0;
        out_code_q <= '0;
        out_gain_q <= 1'b0;
      end else begin
        if (hit) begin
          in_code_q <= cmd_i.code;
          in_gain_q <= cmd_i.gain;
        end
        if (xfer_i) begin
          out_code_q <= in_code_q;
          out_gain_q <= in_gain_q;
        end
        // immediate path wins over a coincident transfer
        if (hit && !hold_i) begin
          out_code_q <= cmd_i.code;
          out_gain_q <= cmd_i.gain;
        end
      end
    end

    assign code_o[c] = out_code_q;
    assign gain_o[c] = out_gain_q;
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   load_i,
  input  logic                   ldac_i,
  output logic [N_CH*CODE_W-1:0] code_o,
  output logic [N_CH-1:0]        gain_o,
  output logic                   err_o
);
  logic [3:0]             lvl;
  logic [2:0]             falls;
  logic                   sclk_fall, load_fall, ldac_fall, ldac_lvl;
  logic                   wr_stb, short_stb;
  cmd_t                   cmd;
  logic [CNT_W-1:0]       bit_cnt;
  logic [N_CH-1:0][CODE_W-1:0] codes;
  logic                   err_q;

  dac_rx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i({ldac_i, load_i, sdata_i, sclk_i}),
    .sync_o (lvl)
  );

  dac_rx_fall #(.W(3)) u_fall (
    .clk_i, .rst_ni,
    .lvl_i ({lvl[3], lvl[2], lvl[0]}),
    .fall_o(falls)
  );

  assign sclk_fall = falls[0];
  assign load_fall = falls[1];
  assign ldac_fall = falls[2];
  assign ldac_lvl  = lvl[3];

  dac_rx_shift u_shift (
    .clk_i, .rst_ni,
    .bit_stb_i(sclk_fall),
    .bit_i    (lvl[1]),
    .latch_i  (load_fall),
    .wr_o     (wr_stb),
    .short_o  (short_stb),
    .cmd_o    (cmd),
    .cnt_o    (bit_cnt)
  );

  dac_rx_bank u_bank (
    .clk_i, .rst_ni,
    .wr_i  (wr_stb),
    .cmd_i (cmd),
    .hold_i(ldac_lvl),
    .xfer_i(ldac_fall),
    .code_o(codes),
    .gain_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (short_stb) err_q <= 1'b1;
    else if (wr_stb)    err_q <= 1'b0;
  end

  assign code_o = codes;
  assign err_o  = err_q;
endmodule

// File: rtl/dac_rx_chk.sv
module dac_rx_chk
  import dac_rx_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH*CODE_W-1:0] code_o,
  input logic [N_CH-1:0]        gain_o,
  input logic                   err_o,
  input logic                   load_fall,
  input logic                   ldac_fall,
  input logic                   ldac_lvl,
  input logic                   wr_stb,
  input logic [CNT_W-1:0]       bit_cnt
);
  // R6
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(load_fall));

  // R6
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |=> !err_o);

  // R7
  out_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $past(ldac_fall || (wr_stb && !ldac_lvl)));

  // R8
  held_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && ldac_lvl) |=> ($stable(code_o) && $stable(gain_o)));

  // R10
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fall |=> (bit_cnt == '0));

  // R5
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt == CNT_W'(CMD_W)) && !load_fall |=> (bit_cnt == CNT_W'(CMD_W)));
endmodule

bind dac_cmd_rx dac_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .code_o   (code_o),
  .gain_o   (gain_o),
  .err_o    (err_o),
  .load_fall(load_fall),
  .ldac_fall(ldac_fall),
  .ldac_lvl (ldac_lvl),
  .wr_stb   (wr_stb),
  .bit_cnt  (bit_cnt)
);

// File: tb/tb_dac_cmd_rx.sv
`timescale 1ns/1ps
module tb_dac_cmd_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1, sdata = 1'b0, load = 1'b1, ldac = 1'b0;
  logic [31:0] code_o;
  logic [3:0]  gain_o;
  logic        err_o;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_in_code [4];
  logic       m_in_gain [4];
  logic [7:0] m_out_code [4];
  logic       m_out_gain [4];
  logic       m_err;

  always #2.5 clk = ~clk;

  dac_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sclk_i(sclk), .sdata_i(sdata), .load_i(load), .ldac_i(ldac),
    .code_o(code_o), .gain_o(gain_o), .err_o(err_o)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // v holds n bits in [n-1:0], sent MSB first
  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      wait_cyc(4);
      sclk = 1'b0;
      wait_cyc(4);
      sclk = 1'b1;
    end
    wait_cyc(4);
    load = 1'b0;
    wait_cyc(6);
    load = 1'b1;
    wait_cyc(8);
    if (n >= 11) begin
      int s = int'(v[10:9]);
      m_in_code[s] = v[7:0];
      m_in_gain[s] = v[8];
      if (!ldac) begin
        m_out_code[s] = v[7:0];
        m_out_gain[s] = v[8];
      end
      m_err = 1'b0;
    end else begin
      m_err = 1'b1;
    end
  endtask

  task automatic pulse_ldac();
    ldac = 1'b0;
    wait_cyc(10);
    for (int c = 0; c < 4; c++) begin
      m_out_code[c] = m_in_code[c];
      m_out_gain[c] = m_in_gain[c];
    end
  endtask

  task automatic check(input string tag);
    logic [31:0] ec;
    logic [3:0]  eg;
    for (int c = 0; c < 4; c++) begin
      ec[c*8 +: 8] = m_out_code[c];
      eg[c]        = m_out_gain[c];
    end
    checks++;
    if (code_o !== ec || gain_o !== eg || err_o !== m_err) begin
      errors++;
      $display("FAIL %s: code=%h gain=%b err=%b expected code=%h gain=%b err=%b",
               tag, code_o, gain_o, err_o, ec, eg, m_err);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_in_code[c] = '0; m_in_gain[c] = 1'b0;
      m_out_code[c] = '0; m_out_gain[c] = 1'b0;
    end
    m_err = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(6);
    check("R1 reset state");

    // immediate path: all channels, both gains, spread codes
    for (int ch = 0; ch < 4; ch++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 16; k++) begin
          logic [7:0] cd = 8'((k * 17) ^ (ch * 37) ^ (g * 90));
          send({5'b0, 2'(ch), 1'(g), cd}, 11);
          check("R2 R3 R4 R7 immediate write");
        end

    // held path: writes invisible until ldac falls
    for (int r = 0; r < 6; r++) begin
      ldac = 1'b1;
      wait_cyc(10);
      for (int ch = 0; ch < 4; ch++) begin
        send({5'b0, 2'(ch), 1'((r + ch) & 1), 8'(r * 41 + ch * 13 + 3)}, 11);
        check("R8 held write leaves outputs");
      end
      pulse_ldac();
      check("R9 simultaneous transfer");
    end

    // long command: leading bits discarded
    send(16'b101_01_1_11001010, 14);
    check("R5 last eleven bits used");
    send(16'b11111_10_0_00110101, 16);
    check("R5 sixteen-bit command");

    // short commands
    send(16'h0055, 7);
    check("R6 short rejected");
    send(16'h0000, 0);
    check("R6 empty command rejected");
    send({5'b0, 2'd3, 1'b1, 8'h81}, 11);
    check("R10 count cleared after reject, R6 err cleared");
    send(16'h03ff, 10);
    check("R10 count cleared after accept");

    // held short command does not write the input register
    ldac = 1'b1;
    wait_cyc(10);
    send(16'h01ff, 9);
    check("R6 held short no write");
    pulse_ldac();
    check("R6 R9 transfer after short");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule